// File: doc/BRIEF.md
# Sparse Tile Row-Pointer Builder

This block builds the per-tile starting-row table for a sparse matrix held in compressed-row form, where the nonzeros have been cut into equal tiles of W×H entries. It reads the row boundary array (entry r is the index of the first nonzero of row r, and entry m equals the nonzero count) through a synchronous read port with one cycle of latency. For each tile boundary it finds, by binary search, the row that holds that tile's first nonzero. It then writes one packed pointer word per tile into a table through a write port.

Each pointer word is unsigned. The low bits hold the row index. The most significant bit marks a tile that spans at least one empty row. Because of this sign-magnitude layout, a marked first tile reads as "negative zero", a value distinct from a plain zero.

A run begins with a one-cycle start pulse that captures the row count, the nonzero count and the tile dimensions. The run ends with a one-cycle done pulse. The block builds each pointer just before it scans the rows of the previous tile, so no pointer storage is needed. The table is written strictly in ascending address order.

Top module: `tile_ptr_gen`

## Requirements
- R1: After reset, and while idle, `rp_rd_en`, `tp_wr_en` and `done` are low.
- R2: A run writes exactly p+1 words, at table addresses 0, 1, …, p in ascending order, each address once. Here p = ceil(nnz / (W·H)).
- R3: The low PTR_W−1 bits of word t hold the largest row r in 0..m with rowptr[r] ≤ t·W·H.
- R4: For t < p, bit PTR_W−1 of word t is 1 exactly when some row r, with index(t) ≤ r ≤ min(index(t+1), m−1), has rowptr[r] = rowptr[r+1]. Word p always has that bit clear.
- R5: If tile 0 starts at row 0 and is marked, its word is 1 in the top bit with all other bits zero (0x8000 for a 16-bit word). This value is distinct from an all-zero word.
- R6: Read data is taken one cycle after `rp_rd_en`, and every read address lies in 0..m.
- R7: `done` is high for exactly one cycle, in the cycle right after the last table write.
- R8: A start pulse while a run is in progress is ignored. The table and the single done pulse follow the inputs captured at the first start.
- R9: A tile width or height of zero is treated as one.
- R10: With nnz = 0 the table has one word: the largest row r with rowptr[r] = 0, with the mark bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; sampled only when idle |
| num_rows | input | ROW_W | Row count m |
| num_nz | input | DATA_W | Nonzero count |
| tile_w | input | DIM_W | Tile width W |
| tile_h | input | DIM_W | Tile height H |
| rp_rd_en | output | 1 | Row boundary array read strobe |
| rp_addr | output | ROW_W | Row boundary array read address |
| rp_rdata | input | DATA_W | Read data, valid one cycle after the strobe |
| tp_wr_en | output | 1 | Pointer table write strobe |
| tp_wr_addr | output | DATA_W | Pointer table write address (tile index) |
| tp_wr_data | output | PTR_W | Pointer word: mark bit on top, row index below |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the block with 5-bit row indices, 8-bit nonzero counts, 3-bit tile dimensions and 16-bit pointer words. This keeps every table short enough to compare word by word against a reference computed in the bench. The size lets the bench sweep row counts of 1, 4, 9 and 16 against six row-length patterns and six tile shapes. The patterns cover uniform rows, scattered empty rows, leading and trailing runs of empty rows, and one long row among empties. Together they reach tiles inside a single row, tiles spanning many rows, final boundaries that fall exactly on nnz, and final boundaries that fall beyond it. Directed runs add the negative-zero first tile, zero nonzeros, a zero tile dimension, and a start pulse in the middle of a run.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [2:0] {
    TP_IDLE, TP_INIT, TP_SEARCH, TP_SCANGO, TP_SCAN, TP_WRITE, TP_LAST, TP_DONE
  } tp_state_e;

  typedef enum logic [1:0] {
    BS_IDLE, BS_PROBE, BS_CMP
  } bs_state_e;

  typedef enum logic [2:0] {
    SC_IDLE, SC_FIRST, SC_HOLD, SC_CMP, SC_FIN
  } sc_state_e;

endpackage

// File: rtl/tpg_bsearch.sv
// Finds the largest row r in 0..rows with rowptr[r] <= key.
module tpg_bsearch
  import tpg_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int DATA_W = 20,
  parameter int KEY_W  = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ROW_W-1:0]  rows,
  input  logic [KEY_W-1:0]  key,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_en,
  output logic [ROW_W-1:0]  rd_addr,
  output logic              found,
  output logic [ROW_W-1:0]  result
);

  bs_state_e        st_q, st_d;
  logic [ROW_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic [ROW_W-1:0] diff, mid;

  // Upper midpoint, written without needing an extra carry bit.
  assign diff = hi_q - lo_q;
  assign mid  = lo_q + (diff >> 1) + {{(ROW_W-1){1'b0}}, diff[0]};

  assign rd_addr = mid;
  assign result  = lo_q;

  always_comb begin
    st_d  = st_q;
    lo_d  = lo_q;
    hi_d  = hi_q;
    rd_en = 1'b0;
    found = 1'b0;
    unique case (st_q)
      BS_IDLE: begin
        if (go) begin
          lo_d = '0;
          hi_d = rows;
          st_d = BS_PROBE;
        end
      end
      BS_PROBE: begin
        if (lo_q == hi_q) begin
          found = 1'b1;
          st_d  = BS_IDLE;
        end else begin
          rd_en = 1'b1;
          st_d  = BS_CMP;
        end
      end
      BS_CMP: begin
        if (KEY_W'(rd_data) <= key) lo_d = mid;
        else                        hi_d = mid - 1'b1;
        st_d = BS_PROBE;
      end
      default: st_d = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= BS_IDLE;
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      st_q <= st_d;
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  // R3: the search window never inverts while a search is active.
  assert_window_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != BS_IDLE) |-> (lo_q <= hi_q));

  // R6: each probe read is followed by the compare that consumes its data.
  assert_probe_then_cmp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (st_q == BS_CMP));

endmodule

// File: rtl/tpg_scan.sv
// Walks rows row_lo..row_hi looking for a pair of equal consecutive boundaries.
module tpg_scan
  import tpg_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int DATA_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              valid,
  input  logic [ROW_W-1:0]  row_lo,
  input  logic [ROW_W-1:0]  row_hi,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_en,
  output logic [ROW_W-1:0]  rd_addr,
  output logic              fin,
  output logic              hit
);

  sc_state_e         st_q, st_d;
  logic [ROW_W-1:0]  rid_q, rid_d, end_q, end_d;
  logic [DATA_W-1:0] held_q, held_d;
  logic              hit_q, hit_d;

  assign hit = hit_q;

  always_comb begin
    st_d    = st_q;
    rid_d   = rid_q;
    end_d   = end_q;
    held_d  = held_q;
    hit_d   = hit_q;
    rd_en   = 1'b0;
    rd_addr = rid_q;
    fin     = 1'b0;
    unique case (st_q)
      SC_IDLE: begin
        if (go) begin
          rid_d = row_lo;
          end_d = row_hi;
          hit_d = 1'b0;
          st_d  = valid ? SC_FIRST : SC_FIN;
        end
      end
      SC_FIRST: begin
        rd_en = 1'b1;
        st_d  = SC_HOLD;
      end
      SC_HOLD: begin
        held_d  = rd_data;
        rd_en   = 1'b1;
        rd_addr = rid_q + 1'b1;
        st_d    = SC_CMP;
      end
      SC_CMP: begin
        if (rd_data == held_q) begin
          hit_d = 1'b1;
          st_d  = SC_FIN;
        end else if (rid_q == end_q) begin
          st_d = SC_FIN;
        end else begin
          held_d  = rd_data;
          rid_d   = rid_q + 1'b1;
          rd_en   = 1'b1;
          rd_addr = rid_q + ROW_W'(2);
        end
      end
      SC_FIN: begin
        fin  = 1'b1;
        st_d = SC_IDLE;
      end
      default: st_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SC_IDLE;
      rid_q  <= '0;
      end_q  <= '0;
      held_q <= '0;
      hit_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      rid_q  <= rid_d;
      end_q  <= end_d;
      held_q <= held_d;
      hit_q  <= hit_d;
    end
  end

  // R4: the compared row never passes the last row of the tile's span.
  assert_scan_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SC_CMP) |-> (rid_q <= end_q));

  // R4: a mark is only raised when leaving the compare step.
  assert_hit_from_cmp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_q) |-> ($past(st_q) == SC_CMP));

endmodule

// File: rtl/tile_ptr_gen.sv
module tile_ptr_gen
  import tpg_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int DATA_W = 20,
  parameter int DIM_W  = 6,
  parameter int PTR_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ROW_W-1:0]  num_rows,
  input  logic [DATA_W-1:0] num_nz,
  input  logic [DIM_W-1:0]  tile_w,
  input  logic [DIM_W-1:0]  tile_h,
  output logic              rp_rd_en,
  output logic [ROW_W-1:0]  rp_addr,
  input  logic [DATA_W-1:0] rp_rdata,
  output logic              tp_wr_en,
  output logic [DATA_W-1:0] tp_wr_addr,
  output logic [PTR_W-1:0]  tp_wr_data,
  output logic              done
);

  localparam int AREA_W = 2 * DIM_W;
  localparam int KEY_W  = ((DATA_W > AREA_W) ? DATA_W : AREA_W) + 1;
  localparam int TAB_W  = DATA_W;

  tp_state_e         st_q, st_d;
  logic [ROW_W-1:0]  rows_q, rows_d, prev_q, prev_d, nxt_q, nxt_d;
  logic [DATA_W-1:0] nnz_q, nnz_d;
  logic [AREA_W-1:0] area_q, area_d, area_in;
  logic [KEY_W-1:0]  key_q, key_d;
  logic [TAB_W-1:0]  tix_q, tix_d;
  logic              first_q, first_d;

  logic [DIM_W-1:0]  w_eff, h_eff;
  logic              key_ge, scan_valid;
  logic [ROW_W-1:0]  scan_last;

  logic              srch_go, s_rd, s_found;
  logic [ROW_W-1:0]  s_addr, s_res;
  logic              scan_go, c_rd, c_fin, c_hit;
  logic [ROW_W-1:0]  c_addr;

  assign w_eff   = (tile_w == '0) ? DIM_W'(1) : tile_w;
  assign h_eff   = (tile_h == '0) ? DIM_W'(1) : tile_h;
  assign area_in = AREA_W'(w_eff) * AREA_W'(h_eff);

  assign key_ge     = key_q >= KEY_W'(nnz_q);
  assign scan_last  = (nxt_q < rows_q) ? nxt_q : (rows_q - 1'b1);
  assign scan_valid = (rows_q != '0) && (prev_q <= scan_last);

  tpg_bsearch #(.ROW_W(ROW_W), .DATA_W(DATA_W), .KEY_W(KEY_W)) u_search (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (srch_go),
    .rows    (rows_q),
    .key     (key_q),
    .rd_data (rp_rdata),
    .rd_en   (s_rd),
    .rd_addr (s_addr),
    .found   (s_found),
    .result  (s_res)
  );

  tpg_scan #(.ROW_W(ROW_W), .DATA_W(DATA_W)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (scan_go),
    .valid   (scan_valid),
    .row_lo  (prev_q),
    .row_hi  (scan_last),
    .rd_data (rp_rdata),
    .rd_en   (c_rd),
    .rd_addr (c_addr),
    .fin     (c_fin),
    .hit     (c_hit)
  );

  assign rp_rd_en   = s_rd | c_rd;
  assign rp_addr    = s_rd ? s_addr : c_addr;
  assign tp_wr_addr = tix_q;

  always_comb begin
    st_d       = st_q;
    rows_d     = rows_q;
    nnz_d      = nnz_q;
    area_d     = area_q;
    key_d      = key_q;
    tix_d      = tix_q;
    prev_d     = prev_q;
    nxt_d      = nxt_q;
    first_d    = first_q;
    srch_go    = 1'b0;
    scan_go    = 1'b0;
    tp_wr_en   = 1'b0;
    tp_wr_data = '0;
    done       = 1'b0;
    unique case (st_q)
      TP_IDLE: begin
        if (start) begin
          rows_d  = num_rows;
          nnz_d   = num_nz;
          area_d  = area_in;
          key_d   = '0;
          tix_d   = '0;
          first_d = 1'b1;
          st_d    = TP_INIT;
        end
      end
      TP_INIT: begin
        srch_go = 1'b1;
        st_d    = TP_SEARCH;
      end
      TP_SEARCH: begin
        if (s_found) begin
          nxt_d = s_res;
          if (first_q) begin
            prev_d  = s_res;
            first_d = 1'b0;
            if (key_ge) begin
              st_d = TP_LAST;
            end else begin
              key_d = key_q + KEY_W'(area_q);
              st_d  = TP_INIT;
            end
          end else begin
            st_d = TP_SCANGO;
          end
        end
      end
      TP_SCANGO: begin
        scan_go = 1'b1;
        st_d    = TP_SCAN;
      end
      TP_SCAN: begin
        if (c_fin) st_d = TP_WRITE;
      end
      TP_WRITE: begin
        tp_wr_en   = 1'b1;
        tp_wr_data = {c_hit, (PTR_W-1)'(prev_q)};
        tix_d      = tix_q + 1'b1;
        prev_d     = nxt_q;
        if (key_ge) begin
          st_d = TP_LAST;
        end else begin
          key_d = key_q + KEY_W'(area_q);
          st_d  = TP_INIT;
        end
      end
      TP_LAST: begin
        tp_wr_en   = 1'b1;
        tp_wr_data = {1'b0, (PTR_W-1)'(nxt_q)};
        st_d       = TP_DONE;
      end
      TP_DONE: begin
        done = 1'b1;
        st_d = TP_IDLE;
      end
      default: st_d = TP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= TP_IDLE;
      rows_q  <= '0;
      nnz_q   <= '0;
      area_q  <= '0;
      key_q   <= '0;
      tix_q   <= '0;
      prev_q  <= '0;
      nxt_q   <= '0;
      first_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      rows_q  <= rows_d;
      nnz_q   <= nnz_d;
      area_q  <= area_d;
      key_q   <= key_d;
      tix_q   <= tix_d;
      prev_q  <= prev_d;
      nxt_q   <= nxt_d;
      first_q <= first_d;
    end
  end

  // R7: done follows directly on a table write.
  assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(tp_wr_en));

  // R7: done lasts one cycle.
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: back-to-back writes go to consecutive addresses.
  assert_write_ascending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tp_wr_en && $past(tp_wr_en)) |-> (tp_wr_addr == $past(tp_wr_addr) + 1'b1));

  // R6: reads stay inside the boundary array and have one owner.
  assert_read_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rp_rd_en |-> (rp_addr <= rows_q));

  assert_one_reader_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_rd && c_rd));

  // R8: captured run settings hold still while busy.
  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != TP_IDLE) |=> ($stable(nnz_q) && $stable(rows_q) && $stable(area_q)));

endmodule

// File: tb/tile_ptr_gen_test.sv
`timescale 1ns/100ps
module tile_ptr_gen_test;

  localparam int RW = 5;
  localparam int DW = 8;
  localparam int MW = 3;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [RW-1:0] num_rows;
  logic [DW-1:0] num_nz;
  logic [MW-1:0] tile_w, tile_h;
  logic          rp_rd_en;
  logic [RW-1:0] rp_addr;
  logic [DW-1:0] rp_rdata;
  logic          tp_wr_en;
  logic [DW-1:0] tp_wr_addr;
  logic [PW-1:0] tp_wr_data;
  logic          done;

  always #2.5 clk = ~clk;

  tile_ptr_gen #(.ROW_W(RW), .DATA_W(DW), .DIM_W(MW), .PTR_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .num_rows(num_rows),
    .num_nz(num_nz), .tile_w(tile_w), .tile_h(tile_h),
    .rp_rd_en(rp_rd_en), .rp_addr(rp_addr), .rp_rdata(rp_rdata),
    .tp_wr_en(tp_wr_en), .tp_wr_addr(tp_wr_addr), .tp_wr_data(tp_wr_data),
    .done(done)
  );

  logic [DW-1:0] rpmem [0:(1<<RW)-1];
  always @(posedge clk) if (rp_rd_en) rp_rdata <= rpmem[rp_addr];

  int            rp [0:(1<<RW)];
  logic [PW-1:0] got [0:255];
  int            gotn [0:255];
  int            nwr, ndone, done_after_wr, bad_addr, cur_m;
  bit            prev_wr;
  int            checks = 0;
  int            errors = 0;

  always @(negedge clk) begin
    if (tp_wr_en) begin
      got[tp_wr_addr] = tp_wr_data;
      gotn[tp_wr_addr] = gotn[tp_wr_addr] + 1;
      nwr = nwr + 1;
    end
    if (done) begin
      ndone = ndone + 1;
      if (prev_wr) done_after_wr = done_after_wr + 1;
    end
    if (rp_rd_en && int'(rp_addr) > cur_m) bad_addr = bad_addr + 1;
    prev_wr = tp_wr_en;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rowlen(input int mode, input int r, input int m);
    case (mode)
      0: return 3;
      1: return (r * 7 + 3) % 5;
      2: return (r == 1) ? 30 : 0;
      3: return (r % 3 == 0) ? 0 : 2;
      4: return (r < 3) ? 0 : 1;
      5: return (r + 3 < m) ? 4 : 0;
      6: return (r == 1) ? 0 : 2;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_ptr(input int key, input int m);
    int res = 0;
    for (int i = 0; i <= m; i++) if (rp[i] <= key) res = i;
    return res;
  endfunction

  task automatic run(input int m, input int w, input int h, input int mode,
                     input bit poke, input string tag);
    int nnz, area, p, cyc;
    rp[0] = 0;
    for (int r = 0; r < m; r++) rp[r+1] = rp[r] + rowlen(mode, r, m);
    nnz = rp[m];
    for (int i = 0; i <= m; i++) rpmem[i] = DW'(rp[i]);
    for (int i = 0; i < 256; i++) begin got[i] = '0; gotn[i] = 0; end
    nwr = 0; ndone = 0; done_after_wr = 0; bad_addr = 0; cur_m = m;
    @(negedge clk);
    num_rows = RW'(m); num_nz = DW'(nnz); tile_w = MW'(w); tile_h = MW'(h);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; num_nz = DW'(1); tile_w = MW'(7); tile_h = MW'(7); num_rows = RW'(1);
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (ndone == 0 && cyc < 4000) begin @(negedge clk); cyc++; end
    repeat (6) @(negedge clk);
    area = ((w == 0) ? 1 : w) * ((h == 0) ? 1 : h);
    p = (nnz + area - 1) / area;
    chk(ndone == 1, {tag, " R7 R8 done pulse count"}, ndone, 1);
    chk(done_after_wr == 1, {tag, " R7 done right after last write"}, done_after_wr, 1);
    chk(nwr == p + 1, {tag, " R2 word count"}, nwr, p + 1);
    chk(bad_addr == 0, {tag, " R6 read address range"}, bad_addr, 0);
    for (int t = 0; t <= p; t++) begin
      int idx, nx, hi, flag, expv;
      idx = exp_ptr(t * area, m);
      flag = 0;
      if (t < p) begin
        nx = exp_ptr((t + 1) * area, m);
        hi = (nx < m) ? nx : m - 1;
        for (int r = idx; r <= hi; r++) if (rp[r] == rp[r+1]) flag = 1;
      end
      expv = (flag << (PW - 1)) | idx;
      // R3 index field, R4 mark bit
      chk(int'(got[t]) == expv && gotn[t] == 1, {tag, " R3 R4 pointer word"},
          int'(got[t]), expv);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; num_rows = '0; num_nz = '0; tile_w = '0; tile_h = '0;
    prev_wr = 1'b0;
    repeat (4) @(negedge clk);
    chk(!rp_rd_en && !tp_wr_en && !done, "R1 reset outputs", {rp_rd_en, tp_wr_en, done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!rp_rd_en && !tp_wr_en && !done, "R1 idle outputs", {rp_rd_en, tp_wr_en, done}, 0);

    // R5: tile 0 begins at row 0 and covers an empty row -> 0x8000.
    run(4, 2, 2, 6, 1'b0, "R5");
    chk(got[0] == 16'h8000, "R5 negative zero word", int'(got[0]), 32768);
    chk(got[0] != 16'h0000, "R5 distinct from zero", int'(got[0]), 32768);

    // R10: no nonzeros at all.
    run(3, 2, 2, 7, 1'b0, "R10");
    chk(nwr == 1 && got[0] == 16'd3, "R10 single word", int'(got[0]), 3);

    // R9: zero width and zero height behave as one.
    run(9, 0, 2, 1, 1'b0, "R9");
    run(9, 3, 0, 3, 1'b0, "R9");

    // R8: start pulsed mid-run with different inputs.
    run(16, 1, 2, 1, 1'b1, "R8");

    // Sweep over rows, patterns and tile shapes.
    foreach (rp[k]) if (k == 0) begin end
    for (int mi = 0; mi < 4; mi++) begin
      int m;
      m = (mi == 0) ? 1 : (mi == 1) ? 4 : (mi == 2) ? 9 : 16;
      for (int mode = 0; mode < 6; mode++)
        for (int w = 1; w <= 3; w += 2)
          for (int h = 1; h <= 4; h = h * 2)
            run(m, w, h, mode, 1'b0, "SWEEP");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule